// File: doc/BRIEF.md
# Write Burst Sequencer with Read Cut-In

This block sits on the controller side of a double-data-rate SDRAM interface. It issues write bursts of `BURST` beats. It lets a read request cut into a write burst that is still running. Each clock cycle of the data phase carries a pair of beats: the even beat travels in the low half of the pair and the odd beat in the high half. Beat 0 is sent in the cycle after the write command.

A read that arrives during a write is held. It is placed on the command bus two cycles after the write phase in which it was seen. The read never comes sooner than two cycles after the write command. The sequencer masks the write beats that the read cuts off and releases the data and strobe lines. It then marks the window in which read data returns.

After each write the block reports how many beats the memory really stored. A bench can use this count to check which words reached the array. Row activation, refresh, start-up and physical-layer calibration are outside this block.

Top module: `wrrd_burst_seq`

## Requirements
- R1: A write request seen while the block is idle produces the write command in the next cycle, with the requested bank and column. The command encodings are NOP=0, write=1 and read=2. In the `BURST/2` cycles after the write command, the data pair for slot j is driven: beat 2j is in the low half and beat 2j+1 is in the high half. In those cycles `dq_oe_o` is high.
- R2: A read request seen during the write phase p (the write command cycle is phase 0) appears as a read command in phase p+2. A read command never follows a write command in the next cycle.
- R3: The read command carries the bank and column of the read request, whatever bank the write uses.
- R4: When a read command at phase r cuts into the burst (r <= BURST/2+1), the number of kept beats is L = 2(r-1) - LAST_GAP. Every driven beat with index >= L has its mask bit set. Mask bit 0 belongs to the even beat and bit 1 to the odd beat. In the read command cycle the mask is 2'b11.
- R5: From the read command cycle onward, `dq_oe_o` and `dqs_oe_o` stay low until the burst ends. The data bus is therefore released for at least one full cycle before read data returns.
- R6: `dqs_oe_o` is high in a data cycle only if at least one of its two beats is not masked.
- R7: After a read command in cycle c, `rd_valid_o` is high in cycles c+CAS_LAT through c+CAS_LAT+BURST/2-1 and in no other cycle.
- R8: While the block is busy, requests have no effect. This covers a write request during a write or a read, and a read request while a read is held or is returning data.
- R9: After each write, `commit_o` holds the kept beat count: L after a cut-in, and BURST otherwise.
- R10: After reset the command is NOP, all enables, masks and `rd_valid_o` are low, and `commit_o` is 0.
- R11: A read request seen while the block is idle produces the read command in the next cycle.
- R12: When a write request and a read request arrive in the same idle cycle, the write goes first and the read command follows at phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req_i | input | 1 | Write request pulse |
| wr_bank_i | input | BANK_W | Write bank |
| wr_col_i | input | COL_W | Write column |
| wr_data_i | input | BURST*DATA_W | Write burst; beat b is at bits [b*DATA_W +: DATA_W] |
| rd_req_i | input | 1 | Read request pulse |
| rd_bank_i | input | BANK_W | Read bank |
| rd_col_i | input | COL_W | Read column |
| cmd_o | output | 2 | Command: 0 NOP, 1 write, 2 read |
| bank_o | output | BANK_W | Bank for the command |
| col_o | output | COL_W | Column for the command |
| wdata_o | output | 2*DATA_W | Beat pair for this cycle |
| dm_o | output | 2 | Per-beat data mask |
| dq_oe_o | output | 1 | Data line drive enable |
| dqs_oe_o | output | 1 | Strobe drive enable |
| rd_valid_o | output | 1 | Read data window |
| commit_o | output | $clog2(BURST+1) | Beats kept by the last write |

## Verification
The hardest case to reach is a read that lands on exactly the write phase that moves the mask boundary. Phase 3 cuts into the final slot, and phase 4 just misses the burst and must not mask anything. A read that arrives together with the write is another such case. The stimulus steps through every write phase, plus the simultaneous case, in a directed sweep. It then draws the phase, the addresses, the data and extra ignored requests at random from a fixed seed. For each case the bench works out the expected mask, enables, read window and kept count from the requirement formulas.

// File: rtl/wrrd_pkg.sv
package wrrd_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_WR  = 2'b01,
    CMD_RD  = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_WR   = 2'b01,
    S_RD   = 2'b10
  } st_e;
endpackage

// File: rtl/wrrd_beat_mask.sv
// Per-beat mask for one data slot: a beat is dropped when a cut-in is
// scheduled and its burst index is at or past the kept-beat limit.
module wrrd_beat_mask #(
  parameter int SL_W  = 2,
  parameter int CNT_W = 4
) (
  input  logic [SL_W-1:0]  slot_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             cut_i,
  output logic [1:0]       mask_o
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign mask_o[g] = cut_i && ((int'(slot_i) * 2 + g) >= int'(lim_i));
  end
endmodule

// File: rtl/wrrd_slot_mux.sv
// Picks the beat pair of one data slot out of the stored burst.
module wrrd_slot_mux #(
  parameter int DATA_W = 16,
  parameter int BURST  = 8,
  parameter int SL_W   = 2
) (
  input  logic [BURST*DATA_W-1:0] data_i,
  input  logic [SL_W-1:0]         slot_i,
  output logic [2*DATA_W-1:0]     pair_o
);
  localparam int HALF = BURST / 2;
  logic [2*DATA_W-1:0] pairs [HALF];

  for (genvar j = 0; j < HALF; j++) begin : g_pair
    assign pairs[j] = data_i[j*2*DATA_W +: 2*DATA_W];
  end

  always_comb begin
    pair_o = '0;
    for (int j = 0; j < HALF; j++) begin
      if (int'(slot_i) == j) pair_o = pairs[j];
    end
  end
endmodule

// File: rtl/wrrd_burst_seq.sv
module wrrd_burst_seq
  import wrrd_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 16,
  parameter int BURST    = 8,
  parameter int CAS_LAT  = 3,
  parameter int LAST_GAP = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_req_i,
  input  logic [BANK_W-1:0]          wr_bank_i,
  input  logic [COL_W-1:0]           wr_col_i,
  input  logic [BURST*DATA_W-1:0]    wr_data_i,
  input  logic                       rd_req_i,
  input  logic [BANK_W-1:0]          rd_bank_i,
  input  logic [COL_W-1:0]           rd_col_i,
  output logic [1:0]                 cmd_o,
  output logic [BANK_W-1:0]          bank_o,
  output logic [COL_W-1:0]           col_o,
  output logic [2*DATA_W-1:0]        wdata_o,
  output logic [1:0]                 dm_o,
  output logic                       dq_oe_o,
  output logic                       dqs_oe_o,
  output logic                       rd_valid_o,
  output logic [$clog2(BURST+1)-1:0] commit_o
);
  localparam int HALF   = BURST / 2;
  localparam int RD_END = CAS_LAT + HALF - 1;
  localparam int PH_W   = $clog2(RD_END + 2);
  localparam int CNT_W  = $clog2(BURST + 1);
  localparam int SL_W   = (HALF > 1) ? $clog2(HALF) : 1;

  // control state
  st_e                     st_q, st_n;
  logic [PH_W-1:0]         ph_q, ph_n;
  logic                    pend_q, pend_n;
  logic [BANK_W-1:0]       pbank_q, pbank_n;
  logic [COL_W-1:0]        pcol_q, pcol_n;
  logic                    cut_q, cut_n;
  logic [CNT_W-1:0]        lim_q, lim_n;
  logic [BURST*DATA_W-1:0] wbuf_q;
  logic                    load_w;

  // registered outputs
  logic [1:0]              cmd_q, cmd_n;
  logic [BANK_W-1:0]       bank_q, bank_n;
  logic [COL_W-1:0]        col_q, col_n;
  logic [2*DATA_W-1:0]     wdata_q, wdata_n;
  logic [1:0]              dm_q, dm_n;
  logic                    oe_q, oe_n, dqs_q, dqs_n, rv_q, rv_n;
  logic [CNT_W-1:0]        commit_q, commit_n;

  logic                    wr_take, rd_take, sched;
  logic [CNT_W-1:0]        lim_calc;
  logic [SL_W-1:0]         slot_sel;
  logic [1:0]              slot_mask;
  logic [2*DATA_W-1:0]     slot_pair;

  assign wr_take  = wr_req_i && (st_q == S_IDLE) && !pend_q;
  assign rd_take  = rd_req_i && !pend_q && (st_q == S_IDLE || st_q == S_WR);
  assign sched    = pend_q || rd_take;
  assign slot_sel = SL_W'(ph_q);

  always_comb begin
    int v;
    v = 2 * (int'(ph_q) + 1) - LAST_GAP;
    lim_calc = (v < 0) ? '0 : CNT_W'(v);
  end

  wrrd_beat_mask #(.SL_W(SL_W), .CNT_W(CNT_W)) u_mask (
    .slot_i(slot_sel), .lim_i(lim_calc), .cut_i(sched), .mask_o(slot_mask)
  );

  wrrd_slot_mux #(.DATA_W(DATA_W), .BURST(BURST), .SL_W(SL_W)) u_mux (
    .data_i(wbuf_q), .slot_i(slot_sel), .pair_o(slot_pair)
  );

  always_comb begin
    st_n     = st_q;
    ph_n     = ph_q;
    pend_n   = sched;
    pbank_n  = rd_take ? rd_bank_i : pbank_q;
    pcol_n   = rd_take ? rd_col_i : pcol_q;
    cut_n    = cut_q;
    lim_n    = lim_q;
    load_w   = 1'b0;
    cmd_n    = CMD_NOP;
    bank_n   = bank_q;
    col_n    = col_q;
    wdata_n  = wdata_q;
    dm_n     = 2'b00;
    oe_n     = 1'b0;
    dqs_n    = 1'b0;
    rv_n     = 1'b0;
    commit_n = commit_q;
    unique case (st_q)
      S_IDLE: begin
        if (wr_take) begin
          st_n   = S_WR;
          ph_n   = '0;
          cmd_n  = CMD_WR;
          bank_n = wr_bank_i;
          col_n  = wr_col_i;
          load_w = 1'b1;
          cut_n  = 1'b0;
        end else if (sched) begin
          st_n   = S_RD;
          ph_n   = '0;
          cmd_n  = CMD_RD;
          bank_n = pbank_n;
          col_n  = pcol_n;
          pend_n = 1'b0;
        end
      end
      S_WR: begin
        if (cut_q) begin
          // read cuts in: drop the beat after it, release the bus
          st_n     = S_RD;
          ph_n     = '0;
          cmd_n    = CMD_RD;
          bank_n   = pbank_q;
          col_n    = pcol_q;
          pend_n   = 1'b0;
          cut_n    = 1'b0;
          dm_n     = 2'b11;
          commit_n = lim_q;
        end else if (int'(ph_q) == HALF) begin
          st_n     = S_IDLE;
          commit_n = CNT_W'(BURST);
        end else begin
          ph_n    = ph_q + PH_W'(1);
          oe_n    = 1'b1;
          wdata_n = slot_pair;
          dm_n    = slot_mask;
          dqs_n   = ~&slot_mask;
          cut_n   = sched;
          lim_n   = lim_calc;
        end
      end
      S_RD: begin
        if (int'(ph_q) == RD_END) begin
          st_n = S_IDLE;
        end else begin
          ph_n = ph_q + PH_W'(1);
          rv_n = (int'(ph_q) + 1) >= CAS_LAT;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      ph_q     <= '0;
      pend_q   <= 1'b0;
      pbank_q  <= '0;
      pcol_q   <= '0;
      cut_q    <= 1'b0;
      lim_q    <= '0;
      cmd_q    <= CMD_NOP;
      bank_q   <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      dm_q     <= 2'b00;
      oe_q     <= 1'b0;
      dqs_q    <= 1'b0;
      rv_q     <= 1'b0;
      commit_q <= '0;
    end else begin
      st_q     <= st_n;
      ph_q     <= ph_n;
      pend_q   <= pend_n;
      pbank_q  <= pbank_n;
      pcol_q   <= pcol_n;
      cut_q    <= cut_n;
      lim_q    <= lim_n;
      cmd_q    <= cmd_n;
      bank_q   <= bank_n;
      col_q    <= col_n;
      wdata_q  <= wdata_n;
      dm_q     <= dm_n;
      oe_q     <= oe_n;
      dqs_q    <= dqs_n;
      rv_q     <= rv_n;
      commit_q <= commit_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load_w) wbuf_q <= wr_data_i;
  end

  assign cmd_o      = cmd_q;
  assign bank_o     = bank_q;
  assign col_o      = col_q;
  assign wdata_o    = wdata_q;
  assign dm_o       = dm_q;
  assign dq_oe_o    = oe_q;
  assign dqs_oe_o   = dqs_q;
  assign rd_valid_o = rv_q;
  assign commit_o   = commit_q;

  // a read never directly follows a write command
  assert_wr_rd_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RD) |-> ($past(cmd_o) != CMD_WR));

  // a read that cuts in masks the beat before and the slot after it
  assert_mask_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RD && $past(dq_oe_o)) |-> (dm_o == 2'b11 && $past(dm_o[1])));

  // bus released at the read command and while data returns
  assert_bus_free_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_RD || rd_valid_o) |-> (!dq_oe_o && !dqs_oe_o));

  // strobe only with data, and never for a fully masked slot
  assert_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    dqs_oe_o |-> (dq_oe_o && dm_o != 2'b11));

  // no command is issued during the read data window
  assert_rd_window_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (cmd_o == CMD_NOP));
endmodule

// File: tb/sim_wrrd_burst_seq.sv
module sim_wrrd_burst_seq;
  localparam int BANK_W = 2, COL_W = 10, DATA_W = 16, BURST = 8;
  localparam int CAS_LAT = 3, LAST_GAP = 1, HALF = BURST / 2;
  localparam int CNT_W = $clog2(BURST + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic wr_req = 0, rd_req = 0;
  logic [BANK_W-1:0] wr_bank = '0, rd_bank = '0;
  logic [COL_W-1:0] wr_col = '0, rd_col = '0;
  logic [BURST*DATA_W-1:0] wr_data = '0;
  logic [1:0] cmd, dm;
  logic [BANK_W-1:0] bank;
  logic [COL_W-1:0] col;
  logic [2*DATA_W-1:0] wdata;
  logic dq_oe, dqs_oe, rd_valid;
  logic [CNT_W-1:0] commit;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  wrrd_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST(BURST),
    .CAS_LAT(CAS_LAT), .LAST_GAP(LAST_GAP)) u0 (
    .clk(clk), .rst(rst), .wr_req_i(wr_req), .wr_bank_i(wr_bank), .wr_col_i(wr_col),
    .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_bank_i(rd_bank), .rd_col_i(rd_col),
    .cmd_o(cmd), .bank_o(bank), .col_o(col), .wdata_o(wdata), .dm_o(dm),
    .dq_oe_o(dq_oe), .dqs_oe_o(dqs_oe), .rd_valid_o(rd_valid), .commit_o(commit));

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int kept(int r);
    return (r > 0 && r <= HALF + 1) ? 2 * (r - 1) - LAST_GAP : BURST;
  endfunction

  function automatic logic [1:0] exp_mask(int t, int r);
    logic [1:0] m = 2'b00;
    int lim = kept(r);
    for (int k = 0; k < 2; k++) if (2 * (t - 1) + k >= lim) m[k] = 1'b1;
    return m;
  endfunction

  task automatic clear_in();
    wr_req = 0; rd_req = 0;
  endtask

  // p: -2 no read, -1 read together with write, 0..HALF read seen in that write phase
  task automatic run_write(int p, bit stray);
    logic [DATA_W-1:0] beats [BURST];
    logic [BANK_W-1:0] wb, rb;
    logic [COL_W-1:0] wc, rc;
    int r, last;
    bit intr;
    string ctag;
    for (int b = 0; b < BURST; b++) beats[b] = DATA_W'($urandom);
    wb = BANK_W'($urandom); rb = BANK_W'(wb + 1 + ($urandom % 3));
    wc = COL_W'($urandom); rc = COL_W'($urandom);
    r = (p == -2) ? -1 : ((p < 0) ? 2 : p + 2);
    intr = (r > 0 && r <= HALF + 1);
    last = (r > 0) ? r + CAS_LAT + HALF + 1 : HALF + 3;
    ctag = (p == -1) ? "R12" : (stray ? "R8" : "R2");
    @(negedge clk);
    wr_req = 1; wr_bank = wb; wr_col = wc;
    for (int b = 0; b < BURST; b++) wr_data[b*DATA_W +: DATA_W] = beats[b];
    if (p == -1) begin rd_req = 1; rd_bank = rb; rd_col = rc; end
    for (int t = 0; t <= last; t++) begin
      logic eoe;
      logic [1:0] edm;
      logic [1:0] ecmd;
      @(negedge clk);
      clear_in();
      ecmd = (t == 0) ? 2'd1 : ((t == r) ? 2'd2 : 2'd0);
      eoe = (t >= 1 && t <= HALF && (r < 0 || t < r));
      edm = eoe ? (intr ? exp_mask(t, r) : 2'b00) : ((t == r && intr) ? 2'b11 : 2'b00);
      chk(t == 0 ? "R1" : ctag, "cmd", 64'(cmd), 64'(ecmd));
      if (t == 0) begin
        chk("R1", "wr bank", 64'(bank), 64'(wb));
        chk("R1", "wr col", 64'(col), 64'(wc));
      end
      if (t == r) begin
        chk("R3", "rd bank", 64'(bank), 64'(rb));
        chk("R3", "rd col", 64'(col), 64'(rc));
      end
      chk("R5", "dq_oe", 64'(dq_oe), 64'(eoe));
      chk("R4", "dm", 64'(dm), 64'(edm));
      chk("R6", "dqs_oe", 64'(dqs_oe), 64'(eoe && edm != 2'b11));
      if (eoe) chk("R1", "wdata", 64'(wdata), 64'({beats[2*(t-1)+1], beats[2*(t-1)]}));
      chk("R7", "rd_valid", 64'(rd_valid),
          64'(r > 0 && t >= r + CAS_LAT && t < r + CAS_LAT + HALF));
      // stimulus for the cycle t
      if (t == p) begin rd_req = 1; rd_bank = rb; rd_col = rc; end
      if (stray && t == 1) begin
        wr_req = 1; wr_bank = ~wb; wr_col = ~wc; wr_data = ~wr_data;
      end
      if (stray && r > 0 && t == r - 1 && t > p) begin
        rd_req = 1; rd_bank = ~rb; rd_col = ~rc;
      end
      if (stray && r > 0 && t == r + 1) begin
        rd_req = 1; rd_bank = ~rb; rd_col = ~rc;
      end
    end
    chk("R9", "commit", 64'(commit), 64'(kept(r)));
  endtask

  task automatic run_read(bit stray);
    logic [BANK_W-1:0] rb = BANK_W'($urandom);
    logic [COL_W-1:0] rc = COL_W'($urandom);
    @(negedge clk);
    rd_req = 1; rd_bank = rb; rd_col = rc;
    for (int t = 0; t <= CAS_LAT + HALF + 1; t++) begin
      @(negedge clk);
      clear_in();
      chk(stray ? "R8" : "R11", "cmd", 64'(cmd), 64'(t == 0 ? 2'd2 : 2'd0));
      if (t == 0) chk("R11", "rd bank", 64'(bank), 64'(rb));
      chk("R7", "rd_valid", 64'(rd_valid), 64'(t >= CAS_LAT && t < CAS_LAT + HALF));
      chk("R5", "dq_oe", 64'(dq_oe), 64'(0));
      if (stray && t == 1) begin wr_req = 1; wr_bank = ~rb; end
      if (stray && t == 2) begin rd_req = 1; rd_bank = ~rb; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10", "cmd", 64'(cmd), 64'(0));
    chk("R10", "enables", 64'({dq_oe, dqs_oe, rd_valid}), 64'(0));
    chk("R10", "dm", 64'(dm), 64'(0));
    chk("R10", "commit", 64'(commit), 64'(0));
    run_write(-2, 1'b0);
    for (int p = -1; p <= HALF; p++) run_write(p, 1'b0);
    for (int p = -1; p <= HALF; p++) run_write(p, 1'b1);
    run_read(1'b0);
    run_read(1'b1);
    for (int i = 0; i < 60; i++) begin
      int sel = int'($urandom % 8);
      if (sel == 7) run_read(1'(($urandom % 2)));
      else run_write(sel - 2, 1'(($urandom % 2)));
    end
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule